// File: doc/BRIEF.md
# On-the-fly linear window scorer

This block applies a linear classifier to every detection window position in a cell grid while the cell features go past exactly once. A feature extractor hands over one cell at a time, in raster order. Each cell carries a vector of FEAT_DIM signed 9-bit elements and the cell's column and row. A cell belongs to up to WIN_W×WIN_H windows. For each window that contains it, the block multiplies the cell vector by the weight slice for the cell's offset inside that window and adds the result to that window's running sum. The features are not kept. The only state between cells is one 17-bit signed partial sum per window still open, held in a column buffer with WIN_H rows of anchor slots.

One multiply-accumulate unit takes one weight pair per cycle and forms two products. It sweeps offsets in row-major order and, inside each offset, element pairs in ascending order. A cell therefore keeps the block busy for WIN_W·WIN_H·FEAT_DIM/2 cycles. Each window is closed when its bottom-right cell has been added. The block then adds a bias, saturates the total and emits it together with the window's anchor and a detect flag. The weights are held in an on-chip memory that is loaded through a write port, so the same hardware can be retargeted to a different object class.

Top module: `svm_window_scorer`

## Requirements
- R1: While reset is held, and once it is released, `cell_ready_o` is 1 and `score_valid_o` is 0.
- R2: A cell is taken on a clock edge where both `cell_valid_i` and `cell_ready_o` are 1. `cell_ready_o` then stays 0 for exactly WIN_W·WIN_H·FEAT_DIM/2 cycles and returns to 1.
- R3: A window anchored at column ax and row ay gets the score `bias + Σ f[k]·w[k]` over all cells (ax+i, ay+j) with 0≤i<WIN_W and 0≤j<WIN_H. Element k of a cell sits at `cell_feat_i[9k+8:9k]`. Weight element k for offset (i,j) is stored in word address `(j·WIN_W+i)·FEAT_DIM/2 + k/2`: even k in bits [3:0] and odd k in bits [7:4], both 4-bit two's complement. `bias_i` is 17-bit two's complement.
- R4: Each window is emitted exactly once. `score_valid_o` pulses for one cycle, in the cycle in which `cell_ready_o` returns to 1 after its bottom-right cell. `win_x_o` and `win_y_o` carry the anchor.
- R5: Only anchors with ax ≤ IMG_W−WIN_W are scored. Cells near the right edge add nothing to windows that would wrap into the next row.
- R6: For each open window, every step (one element pair of one cell) forms `sat(acc + p0 + p1)`, where sat clamps to [−65536, 65535]. The bias is added to that saturated result and the total is clamped again.
- R7: `detect_o` is 1 exactly when the emitted score is strictly greater than `thr_i`, both compared as 17-bit two's complement.
- R8: Weights written while the block is idle apply to every cell taken after the write.
- R9: A new frame, started by sending row 0 again, gives scores that do not depend on any earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wt_we_i | input | 1 | Weight memory write enable |
| wt_addr_i | input | AW | Weight word address |
| wt_data_i | input | 8 | Two 4-bit signed weights |
| bias_i | input | 17 | Signed bias added to each final score |
| thr_i | input | 17 | Signed detect threshold |
| cell_valid_i | input | 1 | Cell feature offered |
| cell_ready_o | output | 1 | Block can take a cell |
| cell_x_i | input | XW | Cell column |
| cell_y_i | input | YW | Cell row |
| cell_feat_i | input | FEAT_DIM·9 | Packed signed cell feature |
| score_valid_o | output | 1 | Final window score present |
| score_o | output | 17 | Signed window score |
| win_x_o | output | XW | Window anchor column |
| win_y_o | output | YW | Window anchor row |
| detect_o | output | 1 | Score exceeds threshold |

## Verification
The bench targets the cells at the right edge of the grid, where anchors must be dropped. A design that wrapped them would emit extra windows or corrupt the sums of the next row's windows. It drives all-extreme features and weights so that the positive clamp is reached on the very last pair step, and sets the bias to −1. A design that clamped only once, after the bias, would report 65535 instead of 65534. A negative bias drives the score past the lower limit, and a wrapping adder would give a large positive score there. The threshold is set equal to the score in both saturation frames, so a design that compared with ≥ would raise detect. Reloading the weights between frames and restarting at row 0 exposes stale partial sums or stale weights as wrong scores.

// File: rtl/svm_scorer_pkg.sv
package svm_scorer_pkg;
  function automatic int sat_to(input int v, input int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/svm_wt_mem.sv
module svm_wt_mem #(
  parameter int DEPTH  = 2304,
  parameter int WORD_W = 8,
  parameter int AW     = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && int'(waddr_i) < DEPTH) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/svm_colbuf.sv
module svm_colbuf #(
  parameter int SLOTS = 16,
  parameter int COLS  = 25,
  parameter int ACC_W = 17,
  parameter int SW    = 4,
  parameter int CW    = 5
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [SW-1:0]           wslot_i,
  input  logic [CW-1:0]           wcol_i,
  input  logic signed [ACC_W-1:0] wdata_i,
  input  logic [SW-1:0]           rslot_i,
  input  logic [CW-1:0]           rcol_i,
  output logic signed [ACC_W-1:0] rdata_o
);
  logic signed [ACC_W-1:0] mem [SLOTS][COLS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wslot_i][wcol_i] <= wdata_i;
  end

  assign rdata_o = mem[rslot_i][rcol_i];
endmodule

// File: rtl/svm_mac2.sv
module svm_mac2
  import svm_scorer_pkg::*;
#(
  parameter int FEAT_W = 9,
  parameter int WT_W   = 4,
  parameter int ACC_W  = 17
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic signed [FEAT_W-1:0] f0_i,
  input  logic signed [FEAT_W-1:0] f1_i,
  input  logic signed [WT_W-1:0]   w0_i,
  input  logic signed [WT_W-1:0]   w1_i,
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam int PW = FEAT_W + WT_W;

  logic signed [PW-1:0] p0;
  logic signed [PW-1:0] p1;
  int total;

  always_comb begin
    p0    = PW'(f0_i) * PW'(w0_i);
    p1    = PW'(f1_i) * PW'(w1_i);
    total = int'(acc_i) + int'(p0) + int'(p1);
    sum_o = ACC_W'(sat_to(total, ACC_W));
  end
endmodule

// File: rtl/svm_window_scorer.sv
module svm_window_scorer
  import svm_scorer_pkg::*;
#(
  parameter int FEAT_DIM = 36,
  parameter int FEAT_W   = 9,
  parameter int WT_W     = 4,
  parameter int ACC_W    = 17,
  parameter int WIN_W    = 8,
  parameter int WIN_H    = 16,
  parameter int IMG_W    = 32,
  parameter int YW       = 8,
  localparam int NPAIR   = FEAT_DIM / 2,
  localparam int DEPTH   = WIN_W * WIN_H * NPAIR,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int XW      = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wt_we_i,
  input  logic [AW-1:0]              wt_addr_i,
  input  logic [2*WT_W-1:0]          wt_data_i,
  input  logic [ACC_W-1:0]           bias_i,
  input  logic [ACC_W-1:0]           thr_i,
  input  logic                       cell_valid_i,
  output logic                       cell_ready_o,
  input  logic [XW-1:0]              cell_x_i,
  input  logic [YW-1:0]              cell_y_i,
  input  logic [FEAT_DIM*FEAT_W-1:0] cell_feat_i,
  output logic                       score_valid_o,
  output logic [ACC_W-1:0]           score_o,
  output logic [XW-1:0]              win_x_o,
  output logic [YW-1:0]              win_y_o,
  output logic                       detect_o
);
  localparam int NCOL = IMG_W - WIN_W + 1;
  localparam int SW   = (WIN_H > 1) ? $clog2(WIN_H) : 1;
  localparam int CW   = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int ICW  = (WIN_W > 1) ? $clog2(WIN_W) : 1;
  localparam int JCW  = (WIN_H > 1) ? $clog2(WIN_H) : 1;
  localparam int PCW  = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int FIW  = $clog2(FEAT_DIM);

  logic                     busy_q;
  logic signed [FEAT_W-1:0] feat_q [FEAT_DIM];
  logic [XW-1:0]            cx_q;
  logic [YW-1:0]            cy_q;
  logic [ICW-1:0]           oi_q;
  logic [JCW-1:0]           oj_q;
  logic [PCW-1:0]           op_q;
  logic signed [ACC_W-1:0]  acc_q;

  logic                     sv_q;
  logic [ACC_W-1:0]         score_q;
  logic [XW-1:0]            wx_q;
  logic [YW-1:0]            wy_q;
  logic                     det_q;

  int                       ax;
  int                       ay;
  logic                     anchor_ok;
  logic                     first_off, last_pair, last_i, last_j, last_step;
  logic [SW-1:0]            slot;
  logic [CW-1:0]            col;
  logic [AW-1:0]            wt_raddr;
  logic [2*WT_W-1:0]        wt_rdata;
  logic signed [ACC_W-1:0]  cb_rdata;
  logic signed [ACC_W-1:0]  base;
  logic signed [ACC_W-1:0]  mac_sum;
  logic signed [ACC_W-1:0]  final_sum;
  logic [FIW-1:0]           fidx0, fidx1;
  logic signed [FEAT_W-1:0] f0, f1;
  logic signed [WT_W-1:0]   w0, w1;
  logic                     cb_we;
  logic                     fire;

  always_comb begin
    ax        = int'(cx_q) - int'(oi_q);
    ay        = int'(cy_q) - int'(oj_q);
    anchor_ok = (ax >= 0) && (ay >= 0) && (ax < NCOL);
    slot      = anchor_ok ? SW'(ay % WIN_H) : '0;
    col       = anchor_ok ? CW'(ax) : '0;
    first_off = (oi_q == '0) && (oj_q == '0);
    last_pair = int'(op_q) == NPAIR - 1;
    last_i    = int'(oi_q) == WIN_W - 1;
    last_j    = int'(oj_q) == WIN_H - 1;
    last_step = busy_q && last_pair && last_i && last_j;
    wt_raddr  = AW'((int'(oj_q) * WIN_W + int'(oi_q)) * NPAIR + int'(op_q));
    fidx0     = FIW'(2 * int'(op_q));
    fidx1     = FIW'(2 * int'(op_q) + 1);
    f0        = feat_q[fidx0];
    f1        = feat_q[fidx1];
    w0        = $signed(wt_rdata[WT_W-1:0]);
    w1        = $signed(wt_rdata[2*WT_W-1:WT_W]);
    // window opens on its top-left cell: start from zero, not the stale slot
    if (op_q != '0)    base = acc_q;
    else if (first_off) base = '0;
    else               base = cb_rdata;
    cb_we     = busy_q && last_pair && anchor_ok;
    fire      = cb_we && last_i && last_j;
    final_sum = ACC_W'(sat_to(int'(mac_sum) + int'($signed(bias_i)), ACC_W));
  end

  svm_wt_mem #(
    .DEPTH (DEPTH),
    .WORD_W(2 * WT_W),
    .AW    (AW)
  ) u_wt (
    .clk_i  (clk_i),
    .we_i   (wt_we_i),
    .waddr_i(wt_addr_i),
    .wdata_i(wt_data_i),
    .raddr_i(wt_raddr),
    .rdata_o(wt_rdata)
  );

  svm_colbuf #(
    .SLOTS(WIN_H),
    .COLS (NCOL),
    .ACC_W(ACC_W),
    .SW   (SW),
    .CW   (CW)
  ) u_cb (
    .clk_i  (clk_i),
    .we_i   (cb_we),
    .wslot_i(slot),
    .wcol_i (col),
    .wdata_i(mac_sum),
    .rslot_i(slot),
    .rcol_i (col),
    .rdata_o(cb_rdata)
  );

  svm_mac2 #(
    .FEAT_W(FEAT_W),
    .WT_W  (WT_W),
    .ACC_W (ACC_W)
  ) u_mac (
    .acc_i(base),
    .f0_i (f0),
    .f1_i (f1),
    .w0_i (w0),
    .w1_i (w1),
    .sum_o(mac_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      for (int k = 0; k < FEAT_DIM; k++) feat_q[k] <= '0;
      cx_q   <= '0;
      cy_q   <= '0;
      oi_q   <= '0;
      oj_q   <= '0;
      op_q   <= '0;
      acc_q  <= '0;
    end else if (!busy_q) begin
      if (cell_valid_i) begin
        busy_q <= 1'b1;
        for (int k = 0; k < FEAT_DIM; k++) feat_q[k] <= cell_feat_i[k*FEAT_W +: FEAT_W];
        cx_q   <= cell_x_i;
        cy_q   <= cell_y_i;
        oi_q   <= '0;
        oj_q   <= '0;
        op_q   <= '0;
      end
    end else begin
      acc_q <= mac_sum;
      if (last_pair) begin
        op_q <= '0;
        if (last_i) begin
          oi_q <= '0;
          if (last_j) begin
            oj_q   <= '0;
            busy_q <= 1'b0;
          end else begin
            oj_q <= oj_q + 1'b1;
          end
        end else begin
          oi_q <= oi_q + 1'b1;
        end
      end else begin
        op_q <= op_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sv_q    <= 1'b0;
      score_q <= '0;
      wx_q    <= '0;
      wy_q    <= '0;
      det_q   <= 1'b0;
    end else begin
      sv_q <= fire;
      if (fire) begin
        score_q <= final_sum;
        wx_q    <= XW'(ax);
        wy_q    <= YW'(ay);
        det_q   <= $signed(final_sum) > $signed(thr_i);
      end
    end
  end

  assign cell_ready_o  = !busy_q;
  assign score_valid_o = sv_q;
  assign score_o       = score_q;
  assign win_x_o       = wx_q;
  assign win_y_o       = wy_q;
  assign detect_o      = det_q;

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_i && cell_ready_o) |=> !cell_ready_o);

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cell_ready_o && !last_step) |=> !cell_ready_o);

  // R4
  valid_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_valid_o |-> cell_ready_o);

  // R5
  anchor_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_valid_o |-> (int'(win_x_o) < NCOL));

  // R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && base >= 0 && f0 >= 0 && f1 >= 0 && w0 >= 0 && w1 >= 0) |-> (mac_sum >= base));
endmodule

// File: tb/sim_svm_window_scorer.sv
`timescale 1ns/1ps
module sim_svm_window_scorer;
  localparam int FD = 8;
  localparam int WW = 2;
  localparam int WH = 2;
  localparam int IW = 4;
  localparam int IH = 3;
  localparam int YWB = 3;
  localparam int NP = FD / 2;
  localparam int NWORD = WW * WH * NP;
  localparam int BUSY = WW * WH * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_we = 1'b0;
  logic [3:0] wt_addr = '0;
  logic [7:0] wt_data = '0;
  logic [16:0] bias = '0;
  logic [16:0] thr = '0;
  logic cell_valid = 1'b0;
  logic cell_ready;
  logic [1:0] cell_x = '0;
  logic [YWB-1:0] cell_y = '0;
  logic [FD*9-1:0] cell_feat = '0;
  logic score_valid;
  logic [16:0] score;
  logic [1:0] win_x;
  logic [YWB-1:0] win_y;
  logic detect;

  always #2 clk = ~clk;

  svm_window_scorer #(
    .FEAT_DIM(FD), .WIN_W(WW), .WIN_H(WH), .IMG_W(IW), .YW(YWB)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wt_we_i(wt_we), .wt_addr_i(wt_addr),
    .wt_data_i(wt_data), .bias_i(bias), .thr_i(thr), .cell_valid_i(cell_valid),
    .cell_ready_o(cell_ready), .cell_x_i(cell_x), .cell_y_i(cell_y),
    .cell_feat_i(cell_feat), .score_valid_o(score_valid), .score_o(score),
    .win_x_o(win_x), .win_y_o(win_y), .detect_o(detect)
  );

  int n_chk = 0;
  int n_fail = 0;
  int emitted = 0;
  int expected_total = 0;
  int exp_s[$];
  int exp_x[$];
  int exp_y[$];
  int exp_d[$];
  string exp_t[$];
  int macc[IH][IW];
  int wm[WW*WH*FD];
  int cur_f[FD];
  int bias_v = 0;
  int thr_v = 0;
  int unsigned seed = 32'h1234_5678;
  string tag = "";

  function automatic int sat17(int v);
    if (v > 65535) return 65535;
    if (v < -65536) return -65536;
    return v;
  endfunction

  function automatic int rnd(int span, int lo);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'((seed >> 10) % span) + lo;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load_weights(int mode);
    for (int a = 0; a < NWORD; a++) begin
      int e0, e1;
      e0 = (mode == 0) ? rnd(16, -8) : -8;
      e1 = (mode == 0) ? rnd(16, -8) : -8;
      wm[2*a] = e0;
      wm[2*a+1] = e1;
      @(negedge clk);
      wt_we = 1'b1;
      wt_addr = 4'(a);
      wt_data = {4'(e1), 4'(e0)};
    end
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  task automatic model_cell(int cx, int cy);
    for (int j = 0; j < WH; j++) begin
      for (int i = 0; i < WW; i++) begin
        int ax, ay, acc, off, fin;
        ax = cx - i;
        ay = cy - j;
        if (ax >= 0 && ay >= 0 && ax <= IW - WW) begin
          off = j * WW + i;
          acc = (i == 0 && j == 0) ? 0 : macc[ay][ax];
          for (int p = 0; p < NP; p++)
            acc = sat17(acc + cur_f[2*p] * wm[off*FD + 2*p] + cur_f[2*p+1] * wm[off*FD + 2*p+1]);
          macc[ay][ax] = acc;
          if (i == WW - 1 && j == WH - 1) begin
            fin = sat17(acc + bias_v);
            exp_s.push_back(fin);
            exp_x.push_back(ax);
            exp_y.push_back(ay);
            exp_d.push_back(fin > thr_v ? 1 : 0);
            exp_t.push_back(tag);
            expected_total++;
          end
        end
      end
    end
  endtask

  task automatic send_cell(int cx, int cy);
    int cnt;
    model_cell(cx, cy);
    @(negedge clk);
    cell_valid = 1'b1;
    cell_x = 2'(cx);
    cell_y = YWB'(cy);
    for (int k = 0; k < FD; k++) cell_feat[k*9 +: 9] = 9'(cur_f[k]);
    @(posedge clk);
    @(negedge clk);
    cell_valid = 1'b0;
    cnt = 0;
    while (!cell_ready) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == BUSY, "R2 busy cycles", cnt, BUSY);
  endtask

  task automatic run_frame(int fmode);
    for (int cy = 0; cy < IH; cy++) begin
      for (int cx = 0; cx < IW; cx++) begin
        for (int k = 0; k < FD; k++)
          cur_f[k] = (fmode == 0) ? rnd(512, -256) : ((fmode == 1) ? -256 : 255);
        send_cell(cx, cy);
      end
    end
  endtask

  task automatic set_bt(int b, int t);
    bias_v = b;
    thr_v = t;
    bias = 17'(b);
    thr = 17'(t);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && score_valid) begin
      emitted++;
      if (exp_s.size() == 0) begin
        chk(1'b0, "R4 unexpected window", emitted, expected_total);
      end else begin
        int es, ex, ey, ed;
        string t;
        es = exp_s.pop_front();
        ex = exp_x.pop_front();
        ey = exp_y.pop_front();
        ed = exp_d.pop_front();
        t = exp_t.pop_front();
        chk(int'($signed(score)) == es, {t, " R3 score"}, int'($signed(score)), es);
        chk(int'(win_x) == ex, {t, " R5 anchor x"}, int'(win_x), ex);
        chk(int'(win_y) == ey, {t, " R4 anchor y"}, int'(win_y), ey);
        chk(int'(detect) == ed, {t, " R7 detect"}, int'(detect), ed);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cell_ready == 1'b1, "R1 ready in reset", int'(cell_ready), 1);
    chk(score_valid == 1'b0, "R1 valid in reset", int'(score_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cell_ready == 1'b1, "R1 ready after reset", int'(cell_ready), 1);
    chk(score_valid == 1'b0, "R1 valid after reset", int'(score_valid), 0);

    load_weights(0);
    tag = "R3 frame";
    set_bt(100, 0);
    run_frame(0);

    tag = "R9 restart";
    set_bt(-300, 200);
    run_frame(0);

    load_weights(0);
    tag = "R8 reload";
    set_bt(0, -50);
    run_frame(0);

    load_weights(1);
    tag = "R6 pos sat";
    set_bt(-1, 65534);
    run_frame(1);

    tag = "R6 neg sat";
    set_bt(-1000, -65536);
    run_frame(2);

    repeat (5) @(negedge clk);
    chk(exp_s.size() == 0, "R4 all windows emitted", exp_s.size(), 0);
    chk(emitted == 30, "R4 window count", emitted, 30);
    chk(expected_total == 30, "R5 expected anchors", expected_total, 30);
    summary();
  end
endmodule